// File: doc/BRIEF.md
# Network Interface Virtual-Channel and Link Allocator

This block picks which buffered packet in a network interface may start sending, and when. The interface has one output link to its router. Each packet slot raises a request, tagged with the virtual network the packet travels on. In the first stage every virtual network has its own round-robin arbiter over all slots. The winner of that arbiter receives the lowest-numbered virtual channel of its network that is both reported free by the downstream side and not already held by another slot.

Slots that hold a channel then compete in a second round-robin arbiter of the same design, which owns the single link. Its winner is announced as a registered one-hot grant, and that slot drives the link in the next cycle. A slot keeps its channel over any number of lost link rounds. It gives the channel back only when it wins the link while flagging its tail flit. After that, the channel can be handed out again.

Top module: `ni_vc_link_alloc`

## Requirements
- R1: While reset is high, and in the first cycle after it, no slot holds a channel and the link grant is all zero.
- R2: Channels of virtual network n are numbered n*VCPER to n*VCPER+VCPER-1. A slot is given only a channel of the network its vnet id named on the granting edge, and only a channel whose vc_free bit was high and that no slot held.
- R3: Each virtual network grants at most one slot per cycle. The granted channel is the lowest-numbered available channel of that network.
- R4: The slots of one virtual network are served round-robin. After a grant to slot w, the search of that network starts at slot w+1 (wrapping to 0), and the pointer of a network moves only when that network grants.
- R5: A virtual network with no available channel grants nothing, and its requesting slots keep waiting.
- R6: A slot that holds a channel keeps the same channel id until it releases it. Its request input is ignored while it holds.
- R7: The link arbiter considers only slots that hold a channel. It is round-robin with its pointer moved past each winner. Its one-hot grant, with the winner's channel id on link_vc, appears the cycle after the edge on which link_rdy was high. A cycle with link_rdy low yields an all-zero grant and leaves the pointer in place.
- R8: A link winner whose slot_tail bit is high gives up its slot's channel on that same edge. The channel may be granted again on the next edge. A slot only loses its channel this way.
- R9: No channel is held by two slots at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_req | input | NSLOT | Slot has a packet waiting for a channel |
| slot_vnet | input | NSLOT*VNW | Virtual-network id per slot, slot s at bits s*VNW upward |
| slot_tail | input | NSLOT | The slot's next flit is its tail |
| vc_free | input | NVNET*VCPER | Downstream reports the channel free |
| link_rdy | input | 1 | Router can take a flit this cycle |
| slot_has_vc | output | NSLOT | Slot currently holds a channel |
| slot_vc | output | NSLOT*VCW | Held channel id per slot, slot s at bits s*VCW upward |
| link_gnt | output | NSLOT | One-hot link grant, registered |
| link_vc | output | VCW | Channel id of the link grant |

## Verification
The bench builds the block with five slots and two virtual networks of two channels each. With fewer channels than slots, networks run dry and requesters starve for a while (R5), and channels are reused after a tail release (R8). The odd slot count makes both kinds of round-robin pointer wrap at a bound that is not a power of two. Random vnet ids often put both networks and the link arbiter to work on the same edge.

// File: rtl/ni_alloc_pkg.sv
package ni_alloc_pkg;

    localparam int DEF_SLOTS        = 4;
    localparam int DEF_VNETS        = 2;
    localparam int DEF_VCS_PER_VNET = 2;

    // widest request vector the pick helpers accept
    localparam int MAX_N = 32;
    localparam int PTR_W = 5;

    typedef logic [PTR_W-1:0] ptr_t;

    // first set bit at or after start, wrapping at n; -1 when none
    function automatic int rr_pick(input logic [MAX_N-1:0] req,
                                   input int start,
                                   input int n);
        int found;
        found = -1;
        for (int k = 0; k < MAX_N; k++) begin
            int j;
            j = (start + k) % n;
            if (k < n && found < 0 && req[PTR_W'(j)])
                found = j;
        end
        return found;
    endfunction

    // lowest set bit below n; -1 when none
    function automatic int low_pick(input logic [MAX_N-1:0] v,
                                    input int n);
        int found;
        found = -1;
        for (int k = MAX_N - 1; k >= 0; k--) begin
            if (k < n && v[k])
                found = k;
        end
        return found;
    endfunction

endpackage

// File: rtl/ni_rr_arb.sv
module ni_rr_arb
    import ni_alloc_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          take,
    output logic          win_ok,
    output logic [IW-1:0] win_idx
);

    ptr_t ptr_q;
    int   pick;

    always_comb pick = rr_pick(MAX_N'(req), int'(ptr_q), N);

    assign win_ok  = (pick >= 0);
    assign win_idx = IW'(pick);

    always_ff @(posedge clk) begin
        if (rst)
            ptr_q <= '0;
        else if (take && win_ok)
            ptr_q <= (pick == N - 1) ? '0 : PTR_W'(pick + 1);
    end

endmodule

// File: rtl/ni_vnet_alloc.sv
module ni_vnet_alloc
    import ni_alloc_pkg::*;
#(
    parameter int NSLOT = 4,
    parameter int VCPER = 2,
    localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int LW = (VCPER > 1) ? $clog2(VCPER) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NSLOT-1:0] req,
    input  logic [VCPER-1:0] avail,
    output logic             fire,
    output logic [SW-1:0]    slot,
    output logic [LW-1:0]    vc_local
);

    logic any_free;
    logic arb_ok;
    int   low;

    assign any_free = |avail;

    // pointer only moves when a channel is actually handed out
    ni_rr_arb #(.N(NSLOT)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .take    (any_free),
        .win_ok  (arb_ok),
        .win_idx (slot)
    );

    always_comb low = low_pick(MAX_N'(avail), VCPER);

    assign vc_local = LW'(low);
    assign fire     = arb_ok & any_free;

endmodule

// File: rtl/ni_slot_vc_table.sv
module ni_slot_vc_table #(
    parameter int NSLOT = 4,
    parameter int NVNET = 2,
    parameter int NVC   = 4,
    localparam int SW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NVNET-1:0]     g_fire,
    input  logic [NVNET*SW-1:0]  g_slot,
    input  logic [NVNET*VCW-1:0] g_vc,
    input  logic                 rel,
    input  logic [SW-1:0]        rel_slot,
    output logic [NSLOT-1:0]     held,
    output logic [NSLOT*VCW-1:0] held_vc,
    output logic [NVC-1:0]       busy
);

    logic [NSLOT-1:0] held_q;
    logic [NVC-1:0]   busy_q;
    logic [VCW-1:0]   vc_q [NSLOT];

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            busy_q <= '0;
            for (int s = 0; s < NSLOT; s++)
                vc_q[s] <= '0;
        end else begin
            // release first; a grant in the same cycle never targets the
            // released channel because busy was still set when it was chosen
            if (rel) begin
                held_q[rel_slot]       <= 1'b0;
                busy_q[vc_q[rel_slot]] <= 1'b0;
            end
            for (int n = 0; n < NVNET; n++) begin
                if (g_fire[n]) begin
                    held_q[g_slot[n*SW +: SW]]   <= 1'b1;
                    vc_q[g_slot[n*SW +: SW]]     <= g_vc[n*VCW +: VCW];
                    busy_q[g_vc[n*VCW +: VCW]]   <= 1'b1;
                end
            end
        end
    end

    assign held = held_q;
    assign busy = busy_q;

    for (genvar s = 0; s < NSLOT; s++) begin : g_flat
        assign held_vc[s*VCW +: VCW] = vc_q[s];
    end

endmodule

// File: rtl/ni_vc_link_alloc.sv
module ni_vc_link_alloc
    import ni_alloc_pkg::*;
#(
    parameter int NSLOT = DEF_SLOTS,
    parameter int NVNET = DEF_VNETS,
    parameter int VCPER = DEF_VCS_PER_VNET,
    localparam int NVC = NVNET * VCPER,
    localparam int SW  = (NSLOT > 1) ? $clog2(NSLOT) : 1,
    localparam int VNW = (NVNET > 1) ? $clog2(NVNET) : 1,
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1,
    localparam int LW  = (VCPER > 1) ? $clog2(VCPER) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSLOT-1:0]     slot_req,
    input  logic [NSLOT*VNW-1:0] slot_vnet,
    input  logic [NSLOT-1:0]     slot_tail,
    input  logic [NVC-1:0]       vc_free,
    input  logic                 link_rdy,
    output logic [NSLOT-1:0]     slot_has_vc,
    output logic [NSLOT*VCW-1:0] slot_vc,
    output logic [NSLOT-1:0]     link_gnt,
    output logic [VCW-1:0]       link_vc
);

    logic [NSLOT-1:0]     held;
    logic [NSLOT*VCW-1:0] held_vc;
    logic [NVC-1:0]       busy;

    logic [NVNET-1:0]     g_fire;
    logic [NVNET*SW-1:0]  g_slot;
    logic [NVNET*VCW-1:0] g_vc;

    // stage one: one arbiter per virtual network
    for (genvar n = 0; n < NVNET; n++) begin : g_vnet
        logic [NSLOT-1:0] vreq;
        logic [VCPER-1:0] avail;
        logic [LW-1:0]    vc_loc;

        for (genvar s = 0; s < NSLOT; s++) begin : g_req
            assign vreq[s] = slot_req[s] & ~held[s]
                           & (slot_vnet[s*VNW +: VNW] == VNW'(n));
        end

        assign avail = vc_free[n*VCPER +: VCPER] & ~busy[n*VCPER +: VCPER];

        ni_vnet_alloc #(.NSLOT(NSLOT), .VCPER(VCPER)) u_va (
            .clk      (clk),
            .rst      (rst),
            .req      (vreq),
            .avail    (avail),
            .fire     (g_fire[n]),
            .slot     (g_slot[n*SW +: SW]),
            .vc_local (vc_loc)
        );

        assign g_vc[n*VCW +: VCW] = VCW'(n * VCPER) + VCW'(vc_loc);
    end

    // stage two: link arbiter over channel holders
    logic          lk_ok;
    logic [SW-1:0] lk_idx;
    logic          lk_fire;
    logic          lk_rel;

    ni_rr_arb #(.N(NSLOT)) u_link (
        .clk     (clk),
        .rst     (rst),
        .req     (held),
        .take    (link_rdy),
        .win_ok  (lk_ok),
        .win_idx (lk_idx)
    );

    assign lk_fire = link_rdy & lk_ok;
    assign lk_rel  = lk_fire & slot_tail[lk_idx];

    ni_slot_vc_table #(.NSLOT(NSLOT), .NVNET(NVNET), .NVC(NVC)) u_tab (
        .clk      (clk),
        .rst      (rst),
        .g_fire   (g_fire),
        .g_slot   (g_slot),
        .g_vc     (g_vc),
        .rel      (lk_rel),
        .rel_slot (lk_idx),
        .held     (held),
        .held_vc  (held_vc),
        .busy     (busy)
    );

    logic [NSLOT-1:0] gnt_q;
    logic [VCW-1:0]   lvc_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gnt_q <= '0;
            lvc_q <= '0;
        end else begin
            gnt_q <= '0;
            if (lk_fire) begin
                gnt_q[lk_idx] <= 1'b1;
                lvc_q         <= held_vc[int'(lk_idx)*VCW +: VCW];
            end
        end
    end

    assign slot_has_vc = held;
    assign slot_vc     = held_vc;
    assign link_gnt    = gnt_q;
    assign link_vc     = lvc_q;

endmodule

// File: rtl/ni_vc_link_alloc_chk.sv
module ni_vc_link_alloc_chk #(
    parameter int NSLOT = 4,
    parameter int NVNET = 2,
    parameter int VCPER = 2,
    localparam int NVC = NVNET * VCPER,
    localparam int VNW = (NVNET > 1) ? $clog2(NVNET) : 1,
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NSLOT*VNW-1:0] slot_vnet,
    input logic                 link_rdy,
    input logic [NSLOT-1:0]     slot_has_vc,
    input logic [NSLOT*VCW-1:0] slot_vc,
    input logic [NSLOT-1:0]     link_gnt
);

    // R1
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (slot_has_vc == '0 && link_gnt == '0));

    // R7
    a_r7_gnt_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(link_gnt));

    a_r7_idle_link: assert property (@(posedge clk) disable iff (rst)
        !link_rdy |=> (link_gnt == '0));

    a_r7_holder_only: assert property (@(posedge clk) disable iff (rst)
        (link_gnt & ~$past(slot_has_vc)) == '0);

    // R9
    logic dup;
    always_comb begin
        dup = 1'b0;
        for (int i = 0; i < NSLOT; i++)
            for (int j = i + 1; j < NSLOT; j++)
                if (slot_has_vc[i] && slot_has_vc[j]
                    && slot_vc[i*VCW +: VCW] == slot_vc[j*VCW +: VCW])
                    dup = 1'b1;
    end

    a_r9_no_shared_vc: assert property (@(posedge clk) disable iff (rst)
        !dup);

    for (genvar s = 0; s < NSLOT; s++) begin : g_slot
        // R6
        a_r6_vc_kept: assert property (@(posedge clk) disable iff (rst)
            ($past(slot_has_vc[s]) && slot_has_vc[s]) |-> $stable(slot_vc[s*VCW +: VCW]));

        // R2
        a_r2_vnet_match: assert property (@(posedge clk) disable iff (rst)
            $rose(slot_has_vc[s]) |->
                (int'(slot_vc[s*VCW +: VCW]) / VCPER == int'($past(slot_vnet[s*VNW +: VNW]))));

        // R8
        a_r8_release_on_link: assert property (@(posedge clk) disable iff (rst)
            $fell(slot_has_vc[s]) |-> link_gnt[s]);
    end

endmodule

bind ni_vc_link_alloc ni_vc_link_alloc_chk #(
    .NSLOT (NSLOT),
    .NVNET (NVNET),
    .VCPER (VCPER)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .slot_vnet   (slot_vnet),
    .link_rdy    (link_rdy),
    .slot_has_vc (slot_has_vc),
    .slot_vc     (slot_vc),
    .link_gnt    (link_gnt)
);

// File: tb/ni_vc_link_alloc_test.sv
`timescale 1ns/1ps
module ni_vc_link_alloc_test;

    localparam int NS  = 5;
    localparam int NV  = 2;
    localparam int VP  = 2;
    localparam int NVC = NV * VP;
    localparam int VNW = (NV > 1) ? $clog2(NV) : 1;
    localparam int VCW = (NVC > 1) ? $clog2(NVC) : 1;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NS-1:0]       slot_req = '0;
    logic [NS*VNW-1:0]   slot_vnet = '0;
    logic [NS-1:0]       slot_tail = '0;
    logic [NVC-1:0]      vc_free = '0;
    logic                link_rdy = 1'b0;
    logic [NS-1:0]       slot_has_vc;
    logic [NS*VCW-1:0]   slot_vc;
    logic [NS-1:0]       link_gnt;
    logic [VCW-1:0]      link_vc;

    always #4 clk = ~clk;

    ni_vc_link_alloc #(.NSLOT(NS), .NVNET(NV), .VCPER(VP)) uut (
        .clk         (clk),
        .rst         (rst),
        .slot_req    (slot_req),
        .slot_vnet   (slot_vnet),
        .slot_tail   (slot_tail),
        .vc_free     (vc_free),
        .link_rdy    (link_rdy),
        .slot_has_vc (slot_has_vc),
        .slot_vc     (slot_vc),
        .link_gnt    (link_gnt),
        .link_vc     (link_vc)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference state
    bit [NS-1:0]  m_held;
    int           m_vc   [NS];
    bit [NVC-1:0] m_busy;
    int           m_vptr [NV];
    int           m_lptr;
    bit [NS-1:0]  m_lgnt;
    int           m_lvc;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int m_rr(input bit [NS-1:0] r, input int start);
        for (int k = 0; k < NS; k++) begin
            int j = (start + k) % NS;
            if (r[j]) return j;
        end
        return -1;
    endfunction

    task automatic m_reset();
        m_held = '0;
        m_busy = '0;
        m_lgnt = '0;
        m_lptr = 0;
        m_lvc  = 0;
        for (int s = 0; s < NS; s++) m_vc[s] = 0;
        for (int n = 0; n < NV; n++) m_vptr[n] = 0;
    endtask

    // next state from the requirements, applied at the coming edge
    task automatic m_step();
        bit [NS-1:0]  nh;
        bit [NVC-1:0] nb;
        int           nvc [NS];
        nh = m_held;
        nb = m_busy;
        for (int s = 0; s < NS; s++) nvc[s] = m_vc[s];
        // R7 / R8
        m_lgnt = '0;
        if (link_rdy) begin
            int w = m_rr(m_held, m_lptr);
            if (w >= 0) begin
                m_lgnt[w] = 1'b1;
                m_lvc     = m_vc[w];
                m_lptr    = (w + 1) % NS;
                if (slot_tail[w]) begin
                    nh[w]          = 1'b0;
                    nb[m_vc[w]]    = 1'b0;
                end
            end
        end
        // R2..R6
        for (int n = 0; n < NV; n++) begin
            bit [NS-1:0] r;
            int lowk = -1;
            for (int s = 0; s < NS; s++)
                r[s] = slot_req[s] && !m_held[s] && (int'(slot_vnet[s*VNW +: VNW]) == n);
            for (int k = VP - 1; k >= 0; k--)
                if (vc_free[n*VP + k] && !m_busy[n*VP + k]) lowk = k;
            if (lowk >= 0) begin
                int w = m_rr(r, m_vptr[n]);
                if (w >= 0) begin
                    nh[w]          = 1'b1;
                    nvc[w]         = n * VP + lowk;
                    nb[n*VP+lowk]  = 1'b1;
                    m_vptr[n]      = (w + 1) % NS;
                end
            end
        end
        m_held = nh;
        m_busy = nb;
        for (int s = 0; s < NS; s++) m_vc[s] = nvc[s];
    endtask

    task automatic compare();
        check(slot_has_vc == m_held, "R2/R3/R4/R5/R6 holders", int'(slot_has_vc), int'(m_held));
        for (int s = 0; s < NS; s++)
            if (m_held[s])
                check(int'(slot_vc[s*VCW +: VCW]) == m_vc[s], "R2/R3/R9 channel id",
                      int'(slot_vc[s*VCW +: VCW]), m_vc[s]);
        check(link_gnt == m_lgnt, "R7/R8 link grant", int'(link_gnt), int'(m_lgnt));
        if (m_lgnt != '0)
            check(int'(link_vc) == m_lvc, "R7 link channel", int'(link_vc), m_lvc);
    endtask

    // called at a negedge with inputs set; returns at the next negedge
    task automatic step();
        @(posedge clk);
        m_step();
        @(negedge clk);
        compare();
    endtask

    task automatic drive_all_vnet(input int vn);
        for (int s = 0; s < NS; s++) slot_vnet[s*VNW +: VNW] = VNW'(vn);
    endtask

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 during reset
        check(slot_has_vc == '0 && link_gnt == '0, "R1 in reset", int'(slot_has_vc), 0);
        rst = 1'b0;
        slot_req = '1;
        drive_all_vnet(0);
        step();
        check(slot_has_vc == '0 && link_gnt == '0, "R1 after reset", int'(slot_has_vc), 0);

        // R5: nothing free, all wait
        repeat (3) step();
        check(slot_has_vc == '0, "R5 no free channel", int'(slot_has_vc), 0);

        // R3/R4: vnet0 fills slot0 then slot1, lowest channel first
        vc_free = '1;
        step();
        check(slot_has_vc == 5'b00001 && slot_vc[0 +: VCW] == 0, "R3 first grant",
              int'(slot_has_vc), 1);
        step();
        check(slot_has_vc == 5'b00011 && int'(slot_vc[VCW +: VCW]) == 1, "R4 next slot",
              int'(slot_has_vc), 3);
        step();
        check(slot_has_vc == 5'b00011, "R5 vnet0 exhausted", int'(slot_has_vc), 3);
        check(link_gnt == '0, "R7 link idle while not ready", int'(link_gnt), 0);

        // R8: tail release and reuse
        slot_tail = '1;
        link_rdy  = 1'b1;
        step();
        check(link_gnt == 5'b00001 && !slot_has_vc[0], "R8 release on tail",
              int'(link_gnt), 1);
        step();
        check(slot_has_vc[2] && slot_vc[2*VCW +: VCW] == 0, "R8 channel reused",
              int'(slot_vc[2*VCW +: VCW]), 0);

        // R6: holders ignore requests; no tail keeps channels
        slot_tail = '0;
        repeat (6) step();

        // random traffic
        void'($urandom(32'h5eed_1234));
        for (int c = 0; c < 4000; c++) begin
            for (int s = 0; s < NS; s++) begin
                slot_req[s]  = ($urandom_range(99, 0) < 60);
                slot_tail[s] = ($urandom_range(99, 0) < 30);
                slot_vnet[s*VNW +: VNW] = VNW'($urandom_range(NV - 1, 0));
            end
            for (int v = 0; v < NVC; v++)
                vc_free[v] = ($urandom_range(99, 0) < ((c / 500) % 2 == 0 ? 85 : 35));
            link_rdy = ($urandom_range(99, 0) < 75);
            step();
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule